// File: doc/BRIEF.md
# Byte-Completion Flag and Transfer-Trigger Unit

This unit sits beside the shift engine of a two-wire serial data port. It turns each end-of-byte strobe into status flags: data register empty, data register full, a general interrupt flag and a transfer-request flag. It also decides whether the completed byte should start a DMA-style transfer engine or be reported to the CPU. A negative acknowledge during a checked transmission never raises the transfer request, so it always reaches software as an interrupt.

The DMA engine starts only on the transfer-request flag. When it has moved its programmed byte count, it pulses a completion input. That pulse clears the empty, interrupt and request flags together, so a continuous stream causes no interrupts. In clocked synchronous mode the unit also asks the bit engine to hold the serial clock after the eighth bit. It does this when the data register is not ready for the next byte, and keeps the hold until software services the register.

Top module: `xfer_flag_ctrl`

## Requirements
- R1: After reset, dr_empty is 1 and dr_full, iric, irtr, dma_start, irq and clk_hold are all 0.
- R2: With ack_chk_en = 0, a transmit byte_done (dir_tx = 1) sets dr_empty, iric and irtr on the next clock edge, whatever the value of ack_bit.
- R3: With ack_chk_en = 1 and ack_bit = 0 (positive acknowledge), a transmit byte_done sets dr_empty, iric and irtr.
- R4: With ack_chk_en = 1 and ack_bit = 1 (negative acknowledge), a transmit byte_done sets only iric. dr_empty and irtr keep their values, and no dma_start pulse is produced.
- R5: A receive byte_done (dir_tx = 0) sets dr_full, iric and irtr and does not consult ack_bit.
- R6: dma_start is high for exactly one cycle, in the same cycle that irtr first reads 1. A byte_done while irtr is already 1 gives no new pulse. After irtr is cleared, the next rise pulses again.
- R7: dma_done clears dr_empty, iric and irtr on the next edge, even when a setting byte_done arrives in the same cycle.
- R8: irq equals iric AND irq_en, combinationally.
- R9: clr_iric and clr_irtr each clear only their own flag. Each wins over a set arriving in the same cycle.
- R10: dr_write clears dr_empty and dr_read clears dr_full. Each wins over a same-cycle set.
- R11: With sync_mode = 1, a byte_done raises clk_hold on the next edge if the direction's flag (dr_empty for transmit, dr_full for receive) reads 1 in that cycle and is not being cleared. clk_hold then stays 1 until dr_write (transmit) or dr_read (receive). The other strobe does not release it.
- R12: With sync_mode = 1 and the direction's flag at 0 when the byte ends, clk_hold stays 0. With sync_mode = 0, clk_hold never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_done | input | 1 | One-cycle strobe at the end of a byte |
| dir_tx | input | 1 | 1 = transmit, 0 = receive |
| ack_bit | input | 1 | Sampled acknowledge, 1 = negative |
| ack_chk_en | input | 1 | Enables acknowledge checking on transmit |
| sync_mode | input | 1 | Clocked synchronous format selected |
| dma_done | input | 1 | Transfer engine finished its byte count |
| clr_iric | input | 1 | Write-one-to-clear for iric |
| clr_irtr | input | 1 | Write-one-to-clear for irtr |
| dr_write | input | 1 | Data register write strobe |
| dr_read | input | 1 | Data register read strobe |
| irq_en | input | 1 | Interrupt enable |
| dr_empty | output | 1 | Data register empty flag |
| dr_full | output | 1 | Data register full flag |
| iric | output | 1 | General interrupt flag |
| irtr | output | 1 | Transfer-request flag |
| dma_start | output | 1 | Single-cycle transfer-engine start |
| irq | output | 1 | Interrupt line |
| clk_hold | output | 1 | Request to hold the serial clock |

## Verification
Transmit byte ends are applied under every combination of acknowledge checking and acknowledge value. The checked-negative case is the only one that must leave irtr low and withhold dma_start. Receive byte ends are driven with a negative acknowledge present, to show the acknowledge is not consulted there. Each clear source (software clear, register access, transfer completion) is made to collide with a setting byte end in the same cycle, which separates clear priority from set priority. The synchronous-mode runs end bytes with the register first serviced and then unserviced in both directions, and offer the wrong-direction strobe as a release.

// File: rtl/xfer_flag_pkg.sv
package xfer_flag_pkg;

  typedef struct packed {
    logic empty;
    logic full;
    logic iric;
    logic irtr;
  } flag_vec_t;

  localparam flag_vec_t FLAGS_RST = '{empty: 1'b1, full: 1'b0, iric: 1'b0, irtr: 1'b0};
  localparam int unsigned FLAG_W = $bits(flag_vec_t);

endpackage

// File: rtl/xfc_event_decode.sv
module xfc_event_decode
  import xfer_flag_pkg::*;
(
  input  logic      byte_done,
  input  logic      dir_tx,
  input  logic      ack_bit,
  input  logic      ack_chk_en,
  output flag_vec_t set_v
);

  logic tx_end;
  logic rx_end;
  logic tx_nack;

  always_comb begin
    tx_end  = byte_done & dir_tx;
    rx_end  = byte_done & ~dir_tx;
    // a checked negative acknowledge only reports to the CPU
    tx_nack = tx_end & ack_chk_en & ack_bit;

    set_v       = '0;
    set_v.empty = tx_end & ~tx_nack;
    set_v.full  = rx_end;
    set_v.iric  = tx_end | rx_end;
    set_v.irtr  = (tx_end & ~tx_nack) | rx_end;
  end

endmodule

// File: rtl/xfc_flag_regs.sv
module xfc_flag_regs
  import xfer_flag_pkg::*;
#(
  parameter flag_vec_t RST_VAL = FLAGS_RST
)(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_v,
  input  flag_vec_t clr_v,
  output flag_vec_t flags_nxt,
  output flag_vec_t flags_q
);

  logic [FLAG_W-1:0] set_b;
  logic [FLAG_W-1:0] clr_b;
  logic [FLAG_W-1:0] nxt_b;
  logic [FLAG_W-1:0] q_b;
  logic [FLAG_W-1:0] rst_b;

  assign set_b = set_v;
  assign clr_b = clr_v;
  assign rst_b = RST_VAL;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    // clear wins over set
    always_comb begin
      nxt_b[i] = (q_b[i] | set_b[i]) & ~clr_b[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_b[i] <= rst_b[i];
      end else begin
        q_b[i] <= nxt_b[i];
      end
    end
  end

  assign flags_nxt = nxt_b;
  assign flags_q   = q_b;

endmodule

// File: rtl/xfc_dma_trig.sv
module xfc_dma_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic req_nxt,
  input  logic req_q,
  output logic start
);

  logic start_nxt;
  logic start_q;

  always_comb begin
    start_nxt = req_nxt & ~req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
    end else begin
      start_q <= start_nxt;
    end
  end

  assign start = start_q;

endmodule

// File: rtl/xfc_clk_hold.sv
module xfc_clk_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_mode,
  input  logic byte_done,
  input  logic dir_tx,
  input  logic empty_q,
  input  logic full_q,
  input  logic dr_write,
  input  logic dr_read,
  output logic hold
);

  logic release_c;
  logic not_ready;
  logic hold_en;
  logic hold_nxt;
  logic hold_q;

  always_comb begin
    release_c = dir_tx ? dr_write : dr_read;
    not_ready = dir_tx ? empty_q  : full_q;
    hold_en   = (sync_mode & byte_done & not_ready & ~release_c) | (hold_q & release_c);
    hold_nxt  = ~hold_q | ~release_c;
    if (!(sync_mode & byte_done & not_ready & ~release_c) && !hold_q) begin
      hold_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (hold_en) begin
      hold_q <= hold_nxt;
    end
  end

  assign hold = hold_q;

endmodule

// File: rtl/xfer_flag_ctrl.sv
module xfer_flag_ctrl
  import xfer_flag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic byte_done,
  input  logic dir_tx,
  input  logic ack_bit,
  input  logic ack_chk_en,
  input  logic sync_mode,
  input  logic dma_done,
  input  logic clr_iric,
  input  logic clr_irtr,
  input  logic dr_write,
  input  logic dr_read,
  input  logic irq_en,
  output logic dr_empty,
  output logic dr_full,
  output logic iric,
  output logic irtr,
  output logic dma_start,
  output logic irq,
  output logic clk_hold
);

  flag_vec_t set_v;
  flag_vec_t clr_v;
  flag_vec_t flags_nxt;
  flag_vec_t flags_q;

  xfc_event_decode i_decode (
    .byte_done  (byte_done),
    .dir_tx     (dir_tx),
    .ack_bit    (ack_bit),
    .ack_chk_en (ack_chk_en),
    .set_v      (set_v)
  );

  always_comb begin
    clr_v       = '0;
    clr_v.empty = dr_write | dma_done;
    clr_v.full  = dr_read;
    clr_v.iric  = clr_iric | dma_done;
    clr_v.irtr  = clr_irtr | dma_done;
  end

  xfc_flag_regs #(.RST_VAL(FLAGS_RST)) i_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_v     (set_v),
    .clr_v     (clr_v),
    .flags_nxt (flags_nxt),
    .flags_q   (flags_q)
  );

  xfc_dma_trig i_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_nxt (flags_nxt.irtr),
    .req_q   (flags_q.irtr),
    .start   (dma_start)
  );

  xfc_clk_hold i_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_mode (sync_mode),
    .byte_done (byte_done),
    .dir_tx    (dir_tx),
    .empty_q   (flags_q.empty),
    .full_q    (flags_q.full),
    .dr_write  (dr_write),
    .dr_read   (dr_read),
    .hold      (clk_hold)
  );

  assign dr_empty = flags_q.empty;
  assign dr_full  = flags_q.full;
  assign iric     = flags_q.iric;
  assign irtr     = flags_q.irtr;
  assign irq      = flags_q.iric & irq_en;

endmodule

// File: rtl/xfer_flag_ctrl_chk.sv
module xfer_flag_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_done,
  input logic dir_tx,
  input logic ack_bit,
  input logic ack_chk_en,
  input logic sync_mode,
  input logic dma_done,
  input logic clr_iric,
  input logic clr_irtr,
  input logic dr_write,
  input logic dr_read,
  input logic dr_empty,
  input logic dr_full,
  input logic iric,
  input logic irtr,
  input logic dma_start,
  input logic clk_hold
);

  // R6
  start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> irtr);

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);

  // R4
  nack_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && dir_tx && ack_chk_en && ack_bit && !irtr) |=> !irtr && !dma_start);

  // R7
  dma_done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> !dr_empty && !iric && !irtr);

  // R9
  clr_iric_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_iric |=> !iric);

  // R10
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dr_write |=> !dr_empty);

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dr_read |=> !dr_full);

  // R11
  hold_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && byte_done && dir_tx && dr_empty && !dr_write) |=> clk_hold);

  // R12
  no_hold_async_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && !clk_hold) |=> !clk_hold);

  // R3
  ack_ok_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && dir_tx && !ack_bit && !dma_done && !dr_write && !clr_iric && !clr_irtr)
      |=> dr_empty && iric && irtr);

endmodule

bind xfer_flag_ctrl xfer_flag_ctrl_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_done  (byte_done),
  .dir_tx     (dir_tx),
  .ack_bit    (ack_bit),
  .ack_chk_en (ack_chk_en),
  .sync_mode  (sync_mode),
  .dma_done   (dma_done),
  .clr_iric   (clr_iric),
  .clr_irtr   (clr_irtr),
  .dr_write   (dr_write),
  .dr_read    (dr_read),
  .dr_empty   (dr_empty),
  .dr_full    (dr_full),
  .iric       (iric),
  .irtr       (irtr),
  .dma_start  (dma_start),
  .clk_hold   (clk_hold)
);

// File: tb/test_xfer_flag_ctrl.sv
`timescale 1ns/1ps
module test_xfer_flag_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_done = 0, dir_tx = 0, ack_bit = 0, ack_chk_en = 0, sync_mode = 0;
  logic dma_done = 0, clr_iric = 0, clr_irtr = 0, dr_write = 0, dr_read = 0, irq_en = 0;
  logic dr_empty, dr_full, iric, irtr, dma_start, irq, clk_hold;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xfer_flag_ctrl i_xfer_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .dir_tx(dir_tx),
    .ack_bit(ack_bit), .ack_chk_en(ack_chk_en), .sync_mode(sync_mode),
    .dma_done(dma_done), .clr_iric(clr_iric), .clr_irtr(clr_irtr),
    .dr_write(dr_write), .dr_read(dr_read), .irq_en(irq_en),
    .dr_empty(dr_empty), .dr_full(dr_full), .iric(iric), .irtr(irtr),
    .dma_start(dma_start), .irq(irq), .clk_hold(clk_hold)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic zero();
    byte_done = 0; ack_bit = 0; dma_done = 0; clr_iric = 0; clr_irtr = 0;
    dr_write = 0; dr_read = 0;
  endtask

  // one edge, then sample 2 ns later and drop the strobes
  task automatic cyc();
    @(posedge clk);
    #2;
    zero();
  endtask

  task automatic clean();
    dr_write = 1; dr_read = 1; clr_iric = 1; clr_irtr = 1;
    cyc();
  endtask

  task automatic t_reset();
    chk("R1", "dr_empty", dr_empty, 1'b1);
    chk("R1", "dr_full", dr_full, 1'b0);
    chk("R1", "iric", iric, 1'b0);
    chk("R1", "irtr", irtr, 1'b0);
    chk("R1", "dma_start", dma_start, 1'b0);
    chk("R1", "irq", irq, 1'b0);
    chk("R1", "clk_hold", clk_hold, 1'b0);
  endtask

  task automatic t_ack_off();
    clean();
    dir_tx = 1; ack_chk_en = 0; ack_bit = 1; byte_done = 1;
    cyc();
    chk("R2", "dr_empty", dr_empty, 1'b1);
    chk("R2", "iric", iric, 1'b1);
    chk("R2", "irtr", irtr, 1'b1);
    chk("R6", "dma_start rise", dma_start, 1'b1);
    cyc();
    chk("R6", "dma_start one cycle", dma_start, 1'b0);
    dir_tx = 1; byte_done = 1;
    cyc();
    chk("R6", "no pulse while irtr set", dma_start, 1'b0);
  endtask

  task automatic t_ack_ok();
    clean();
    dir_tx = 1; ack_chk_en = 1; ack_bit = 0; byte_done = 1;
    cyc();
    chk("R3", "dr_empty", dr_empty, 1'b1);
    chk("R3", "iric", iric, 1'b1);
    chk("R3", "irtr", irtr, 1'b1);
    chk("R3", "dma_start", dma_start, 1'b1);
    ack_chk_en = 0;
  endtask

  task automatic t_nack();
    clean();
    dir_tx = 1; ack_chk_en = 1; ack_bit = 1; byte_done = 1; irq_en = 1;
    cyc();
    chk("R4", "dr_empty", dr_empty, 1'b0);
    chk("R4", "iric", iric, 1'b1);
    chk("R4", "irtr", irtr, 1'b0);
    chk("R4", "dma_start", dma_start, 1'b0);
    chk("R8", "irq enabled", irq, 1'b1);
    irq_en = 0; #1;
    chk("R8", "irq disabled", irq, 1'b0);
    ack_chk_en = 0;
  endtask

  task automatic t_rx();
    clean();
    dir_tx = 0; ack_chk_en = 1; ack_bit = 1; byte_done = 1;
    cyc();
    chk("R5", "dr_full", dr_full, 1'b1);
    chk("R5", "iric", iric, 1'b1);
    chk("R5", "irtr", irtr, 1'b1);
    chk("R5", "dr_empty", dr_empty, 1'b0);
    ack_chk_en = 0;
  endtask

  task automatic t_dma_done();
    clean();
    dir_tx = 1; byte_done = 1;
    cyc();
    dma_done = 1;
    cyc();
    chk("R7", "dr_empty", dr_empty, 1'b0);
    chk("R7", "iric", iric, 1'b0);
    chk("R7", "irtr", irtr, 1'b0);
    dma_done = 1; dir_tx = 1; byte_done = 1;
    cyc();
    chk("R7", "collide iric", iric, 1'b0);
    chk("R7", "collide irtr", irtr, 1'b0);
    chk("R7", "collide empty", dr_empty, 1'b0);
  endtask

  task automatic t_w1c();
    clean();
    dir_tx = 1; byte_done = 1;
    cyc();
    clr_iric = 1;
    cyc();
    chk("R9", "iric cleared", iric, 1'b0);
    chk("R9", "irtr kept", irtr, 1'b1);
    clr_irtr = 1; dir_tx = 1; byte_done = 1;
    cyc();
    chk("R9", "irtr clear wins", irtr, 1'b0);
    chk("R9", "iric set by byte", iric, 1'b1);
    dir_tx = 1; byte_done = 1;
    cyc();
    chk("R6", "re-armed pulse", dma_start, 1'b1);
  endtask

  task automatic t_dr();
    clean();
    dr_write = 1; dir_tx = 1; byte_done = 1;
    cyc();
    chk("R10", "write wins empty", dr_empty, 1'b0);
    chk("R10", "iric still set", iric, 1'b1);
    dr_read = 1; dir_tx = 0; byte_done = 1;
    cyc();
    chk("R10", "read wins full", dr_full, 1'b0);
  endtask

  task automatic t_hold_tx();
    clean();
    sync_mode = 1;
    dir_tx = 1; byte_done = 1;
    cyc();
    chk("R12", "tx ready no hold", clk_hold, 1'b0);
    dir_tx = 1; byte_done = 1;
    cyc();
    chk("R11", "tx hold", clk_hold, 1'b1);
    dr_read = 1;
    cyc();
    chk("R11", "read keeps tx hold", clk_hold, 1'b1);
    dr_write = 1;
    cyc();
    chk("R11", "write releases", clk_hold, 1'b0);
  endtask

  task automatic t_hold_rx();
    clean();
    sync_mode = 1;
    dir_tx = 0; byte_done = 1;
    cyc();
    chk("R12", "rx ready no hold", clk_hold, 1'b0);
    dir_tx = 0; byte_done = 1;
    cyc();
    chk("R11", "rx hold", clk_hold, 1'b1);
    dr_write = 1;
    cyc();
    chk("R11", "write keeps rx hold", clk_hold, 1'b1);
    dr_read = 1;
    cyc();
    chk("R11", "read releases", clk_hold, 1'b0);
    sync_mode = 0;
    dir_tx = 0; byte_done = 1;
    cyc();
    dir_tx = 0; byte_done = 1;
    cyc();
    chk("R12", "no hold outside sync", clk_hold, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    t_reset();
    t_ack_off();
    t_ack_ok();
    t_nack();
    t_rx();
    t_dma_done();
    t_w1c();
    t_dr();
    t_hold_tx();
    t_hold_rx();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule